// File: doc/BRIEF.md
# Pin Port With Peripheral Direction Takeover

An eight-pin general-purpose I/O port driven from a small register bus. Software sets a per-pin direction word, a per-pin reduced-drive word and an output data word. The port drives the pad enable, pad data and drive-strength outputs from registers. A readback word at the data offset shows the driven value for pins that are outputs, and the pad level for pins that are inputs. The pad level passes through a two-flop synchronizer before it is read.

Three neighbouring serial blocks can take over pins. These are one SPI block on the upper four pins and two UART channels on the lower four pins. UART channel k has its receive pin at 2k and its transmit pin at 2k+1. While a block's enable is high, it decides the direction of its pins, and the direction bits for those pins are ignored. When the enable drops, the pin follows the direction register again. The SPI block gives its own output enable for each pin. This lets it drive clock, data-out and select as a master, or only its data line as a slave.

Top module: `gpio_ovr_port`

## Requirements
- R1: With no takeover active, a direction bit of 1 makes the pin an output (`pad_oe` bit 1) and a 0 makes it an input (`pad_oe` bit 0).
- R2: After reset, the direction, drive and output data registers hold zero, `pad_oe`, `pad_do` and `pad_lowdrv` are zero, and a read of any offset returns zero while the pads are low.
- R3: Direction (offset 0xA) and drive (offset 0xB) can be written and read back at any time. `bus_rdata` holds the value from the cycle after `bus_rd`. A write to offset 0x8 loads the output data register.
- R4: While `spi_en` is 1, pins 7:4 take `pad_oe` from `spi_oe[3:0]` and `pad_do` from `spi_do[3:0]` (pin 4+j from bit j). Direction bits 7:4 are ignored.
- R5: While `uart_tx_en[k]` is 1, pin 2k+1 is an output that drives `uart_txd[k]`, whatever its direction bit holds.
- R6: While `uart_rx_en[k]` is 1, pin 2k is an input, whatever its direction bit holds.
- R7: When a takeover enable returns to 0, the affected pins follow the direction and output data registers again.
- R8: A read of offset 0x8 returns, per pin, the driven `pad_do` value if the pin is an output and the synchronized `pad_di` level if it is an input.
- R9: A `pad_di` change made before rising edge E1 is not visible in a data-offset read captured at E2. It is visible in a read captured at E3.
- R10: `pad_lowdrv` follows the drive bit for output pins and is 0 for input pins.
- R11: Offsets other than 0x8, 0xA and 0xB read as zero, and writes to them change no register.
- R12: The pad outputs are registered. A direction write taken at edge E1 reaches `pad_oe` at E2, not at E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Registered read data |
| spi_en | input | 1 | SPI takeover of the upper pins |
| spi_oe | input | SPI_PINS | SPI per-pin output enable |
| spi_do | input | SPI_PINS | SPI per-pin output data |
| uart_tx_en | input | NUM_UART | UART transmitter enables |
| uart_rx_en | input | NUM_UART | UART receiver enables |
| uart_txd | input | NUM_UART | UART transmit data |
| pad_di | input | PORT_W | Pad input level (asynchronous) |
| pad_do | output | PORT_W | Pad output data |
| pad_oe | output | PORT_W | Pad output enable |
| pad_lowdrv | output | PORT_W | Reduced-drive select per pad |

## Verification
The bench builds the block with its default parameters: eight pins, four SPI pins, two UART channels and a two-stage synchronizer. This configuration is small enough to sweep every direction word against every one of the 32 combinations of the five takeover enables. For each combination, the bench computes the expected enable, data, drive and readback words arithmetically. Directed sequences add cycle-exact checks of the synchronizer and pad-register latency, the release of a takeover, and writes to every undefined offset.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int OFS_DATA = 8;
  localparam int OFS_DIR  = 10;
  localparam int OFS_DRV  = 11;

  typedef enum logic [1:0] {
    OWN_REG = 2'd0,
    OWN_SPI = 2'd1,
    OWN_UTX = 2'd2,
    OWN_URX = 2'd3
  } pin_owner_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] rb_val,
  output logic [PORT_W-1:0] dout_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] drv_q,
  output logic [PORT_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(OFS_DRV);

  // register writes; undefined offsets fall through untouched
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else if (wr) begin
      if (addr == A_DATA) dout_q <= wdata;
      if (addr == A_DIR)  dir_q  <= wdata;
      if (addr == A_DRV)  drv_q  <= wdata;
    end
  end

  logic [PORT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == A_DATA) rd_mux = rb_val;
    if (addr == A_DIR)  rd_mux = dir_q;
    if (addr == A_DRV)  rd_mux = drv_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int PORT_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout
);
  logic [PORT_W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_route.sv
module gpio_ovr_route
  import gpio_ovr_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int SPI_PINS = 4,
  parameter int NUM_UART = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PORT_W-1:0]   dir,
  input  logic [PORT_W-1:0]   drv,
  input  logic [PORT_W-1:0]   dout,
  input  logic                spi_en,
  input  logic [SPI_PINS-1:0] spi_oe,
  input  logic [SPI_PINS-1:0] spi_do,
  input  logic [NUM_UART-1:0] tx_en,
  input  logic [NUM_UART-1:0] rx_en,
  input  logic [NUM_UART-1:0] txd,
  output logic [PORT_W-1:0]   pad_oe,
  output logic [PORT_W-1:0]   pad_do,
  output logic [PORT_W-1:0]   pad_lowdrv
);
  localparam int SPI_BASE = PORT_W - SPI_PINS;
  localparam int UART_TOP = 2 * NUM_UART;

  logic [PORT_W-1:0] eff_oe;
  logic [PORT_W-1:0] eff_do;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    pin_owner_e own;
    logic       alt_oe;
    logic       alt_do;

    if (i >= SPI_BASE) begin : g_spi
      assign own    = spi_en ? OWN_SPI : OWN_REG;
      assign alt_oe = spi_oe[i-SPI_BASE];
      assign alt_do = spi_do[i-SPI_BASE];
    end else if (i < UART_TOP && (i % 2) == 1) begin : g_tx
      assign own    = tx_en[i/2] ? OWN_UTX : OWN_REG;
      assign alt_oe = 1'b1;
      assign alt_do = txd[i/2];
    end else if (i < UART_TOP) begin : g_rx
      assign own    = rx_en[i/2] ? OWN_URX : OWN_REG;
      assign alt_oe = 1'b0;
      assign alt_do = dout[i];
    end else begin : g_plain
      assign own    = OWN_REG;
      assign alt_oe = dir[i];
      assign alt_do = dout[i];
    end

    assign eff_oe[i] = (own == OWN_REG) ? dir[i]  : alt_oe;
    assign eff_do[i] = (own == OWN_REG) ? dout[i] : alt_do;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe     <= '0;
      pad_do     <= '0;
      pad_lowdrv <= '0;
    end else begin
      pad_oe     <= eff_oe;
      pad_do     <= eff_do;
      pad_lowdrv <= eff_oe & drv;
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SPI_PINS    = 4,
  parameter int NUM_UART    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [PORT_W-1:0]   bus_wdata,
  output logic [PORT_W-1:0]   bus_rdata,
  input  logic                spi_en,
  input  logic [SPI_PINS-1:0] spi_oe,
  input  logic [SPI_PINS-1:0] spi_do,
  input  logic [NUM_UART-1:0] uart_tx_en,
  input  logic [NUM_UART-1:0] uart_rx_en,
  input  logic [NUM_UART-1:0] uart_txd,
  input  logic [PORT_W-1:0]   pad_di,
  output logic [PORT_W-1:0]   pad_do,
  output logic [PORT_W-1:0]   pad_oe,
  output logic [PORT_W-1:0]   pad_lowdrv
);
  logic [PORT_W-1:0] dout_q, dir_q, drv_q;
  logic [PORT_W-1:0] din_sync;
  logic [PORT_W-1:0] rb_val;

  // readback: driven value on outputs, synchronized level on inputs
  assign rb_val = (pad_oe & pad_do) | (~pad_oe & din_sync);

  gpio_ovr_regs #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rb_val(rb_val), .dout_q(dout_q), .dir_q(dir_q),
    .drv_q(drv_q), .rdata(bus_rdata)
  );

  gpio_ovr_route #(.PORT_W(PORT_W), .SPI_PINS(SPI_PINS), .NUM_UART(NUM_UART)) u_route (
    .clk(clk), .rst(rst), .dir(dir_q), .drv(drv_q), .dout(dout_q),
    .spi_en(spi_en), .spi_oe(spi_oe), .spi_do(spi_do),
    .tx_en(uart_tx_en), .rx_en(uart_rx_en), .txd(uart_txd),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_lowdrv(pad_lowdrv)
  );

  gpio_ovr_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_di), .dout(din_sync)
  );
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk
  import gpio_ovr_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int SPI_PINS = 4,
  parameter int NUM_UART = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_rd,
  input logic [PORT_W-1:0]   bus_rdata,
  input logic                spi_en,
  input logic [SPI_PINS-1:0] spi_oe,
  input logic [SPI_PINS-1:0] spi_do,
  input logic [NUM_UART-1:0] uart_tx_en,
  input logic [NUM_UART-1:0] uart_rx_en,
  input logic [NUM_UART-1:0] uart_txd,
  input logic [PORT_W-1:0]   pad_do,
  input logic [PORT_W-1:0]   pad_oe,
  input logic [PORT_W-1:0]   pad_lowdrv
);
  logic undef_addr;
  assign undef_addr = (bus_addr != ADDR_W'(OFS_DATA)) &&
                      (bus_addr != ADDR_W'(OFS_DIR)) &&
                      (bus_addr != ADDR_W'(OFS_DRV));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_lowdrv == '0 && pad_do == '0 && bus_rdata == '0)); // R2

  AST_SPI_TAKES_PINS: assert property (@(posedge clk) disable iff (rst)
    spi_en |=> (pad_oe[PORT_W-1 -: SPI_PINS] == $past(spi_oe) &&
                pad_do[PORT_W-1 -: SPI_PINS] == $past(spi_do))); // R4

  for (genvar k = 0; k < NUM_UART; k++) begin : g_uart
    AST_TX_DRIVES: assert property (@(posedge clk) disable iff (rst)
      uart_tx_en[k] |=> (pad_oe[2*k+1] && pad_do[2*k+1] == $past(uart_txd[k]))); // R5
    AST_RX_FLOATS: assert property (@(posedge clk) disable iff (rst)
      uart_rx_en[k] |=> !pad_oe[2*k]); // R6
  end

  AST_LOWDRV_ONLY_OUT: assert property (@(posedge clk) disable iff (rst)
    (pad_lowdrv & ~pad_oe) == '0); // R10

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && undef_addr) |=> bus_rdata == '0); // R11
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .PORT_W(PORT_W), .ADDR_W(ADDR_W), .SPI_PINS(SPI_PINS), .NUM_UART(NUM_UART)
) u_chk (.*);

// File: tb/tb_gpio_ovr_port.sv
`timescale 1ns/1ps
module tb_gpio_ovr_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_en = 1'b0;
  logic [3:0] spi_oe = '0;
  logic [3:0] spi_do = '0;
  logic [1:0] uart_tx_en = '0;
  logic [1:0] uart_rx_en = '0;
  logic [1:0] uart_txd = '0;
  logic [7:0] pad_di = '0;
  logic [7:0] pad_do, pad_oe, pad_lowdrv;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_ovr_port dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] exp_oe(logic [7:0] dir, logic se, logic [3:0] soe,
                                        logic [1:0] tx, logic [1:0] rx);
    logic [7:0] r = dir;
    if (se) r[7:4] = soe;
    for (int k = 0; k < 2; k++) begin
      if (tx[k]) r[2*k+1] = 1'b1;
      if (rx[k]) r[2*k]   = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_do(logic [7:0] dout, logic se, logic [3:0] sdo,
                                        logic [1:0] tx, logic [1:0] txd);
    logic [7:0] r = dout;
    if (se) r[7:4] = sdo;
    for (int k = 0; k < 2; k++)
      if (tx[k]) r[2*k+1] = txd[k];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk("R2 pad_oe", pad_oe, 8'h00);
    chk("R2 pad_do", pad_do, 8'h00);
    chk("R2 pad_lowdrv", pad_lowdrv, 8'h00);
    rd(4'hA, v); chk("R2 dir", v, 8'h00);
    rd(4'hB, v); chk("R2 drv", v, 8'h00);
    rd(4'h8, v); chk("R2 data", v, 8'h00);

    // R3 register access
    wr(4'hA, 8'h5A); rd(4'hA, v); chk("R3 dir readback", v, 8'h5A);
    wr(4'hB, 8'hC3); rd(4'hB, v); chk("R3 drv readback", v, 8'hC3);
    wr(4'h8, 8'h96); @(negedge clk);
    chk("R3 data reg to pads", pad_do, 8'h96);

    // R12 pad latency: write taken at E1, pad_oe moves at E2
    wr(4'hA, 8'h00); wr(4'hB, 8'h00); @(negedge clk);
    bus_addr = 4'hA; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R12 pad_oe after E1", pad_oe, 8'h00);
    @(negedge clk);
    chk("R12 pad_oe after E2", pad_oe, 8'hFF);

    // R9 synchronizer latency
    wr(4'hA, 8'h00); pad_di = 8'h00; repeat (4) @(negedge clk);
    pad_di = 8'hE7; bus_addr = 4'h8; bus_rd = 1'b1;
    @(negedge clk); chk("R9 read at E1", bus_rdata, 8'h00);
    @(negedge clk); chk("R9 read at E2", bus_rdata, 8'h00);
    @(negedge clk); chk("R9 read at E3", bus_rdata, 8'hE7);
    bus_rd = 1'b0;

    // R7 release of takeover
    wr(4'hA, 8'h0F); wr(4'h8, 8'h00);
    spi_en = 1'b1; spi_oe = 4'hF; uart_rx_en = 2'b11; uart_tx_en = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R4 takeover on", pad_oe, 8'hFA);
    spi_en = 1'b0; uart_rx_en = 2'b00;
    @(negedge clk);
    chk("R7 fallback pad_oe", pad_oe, 8'h0F);
    chk("R7 fallback pad_do", pad_do, 8'h00);

    // R11 undefined offsets
    wr(4'hA, 8'h12); wr(4'hB, 8'h34); wr(4'h8, 8'h00);
    for (int a = 0; a < 16; a++) begin
      if (a != 8 && a != 10 && a != 11) wr(4'(a), 8'hFF);
    end
    for (int a = 0; a < 16; a++) begin
      if (a != 8 && a != 10 && a != 11) begin
        rd(4'(a), v); chk("R11 undefined read", v, 8'h00);
      end
    end
    rd(4'hA, v); chk("R11 dir kept", v, 8'h12);
    rd(4'hB, v); chk("R11 drv kept", v, 8'h34);
    chk("R11 data kept", pad_do, 8'h00);

    // Sweep: every direction word x every enable combination
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dir, drv, dout, di;
      dir  = 8'(d);
      drv  = {dir[3:0], dir[7:4]} ^ 8'h5A;
      dout = dir ^ 8'hC3;
      di   = 8'(d * 7 + 3);
      pad_di = di;
      spi_en = 1'b0; uart_tx_en = '0; uart_rx_en = '0;
      wr(4'hA, dir); wr(4'hB, drv); wr(4'h8, dout);
      for (int c = 0; c < 32; c++) begin
        logic [7:0] eo, ed;
        @(negedge clk);
        spi_en     = c[0];
        uart_tx_en = 2'(c >> 1);
        uart_rx_en = 2'(c >> 3);
        spi_oe     = ~dir[7:4] ^ 4'(c * 3);
        spi_do     = dir[3:0] ^ 4'(c);
        uart_txd   = 2'(c >> 2) ^ dir[1:0];
        eo = exp_oe(dir, spi_en, spi_oe, uart_tx_en, uart_rx_en);
        ed = exp_do(dout, spi_en, spi_do, uart_tx_en, uart_txd);
        @(negedge clk);
        if (c == 0) chk("R1 R7 pad_oe", pad_oe, eo);
        else        chk("R4 R5 R6 pad_oe", pad_oe, eo);
        chk("R4 R5 pad_do", pad_do, ed);
        chk("R10 pad_lowdrv", pad_lowdrv, drv & eo);
        rd(4'h8, v);
        chk("R8 readback", v, (eo & ed) | (~eo & di));
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule